// File: doc/BRIEF.md
# Two-Frame Serial Register Access Master

This block lets on-chip logic read and write the 16-bit registers of an external display-bridge device over a three-wire style serial link. The link has an active-low select, a serial clock, a master-to-slave data line and an optional slave-to-master data line. A request carries an 8-bit register number, a 16-bit value and a direction flag. It is accepted whenever the block is idle.

Every access is two select-framed 24-bit words. The first word always names the register. The second word either carries the value to store or fetches the register contents. In each word, an 8-bit opcode in the top byte tells the device which of these three kinds of word it is. The bits are shifted out most significant first on a clock that idles high. Data changes while the clock is low, and the device samples on the rising edge.

On a read, the master captures the returned line once per bit, just before each rising edge, and keeps the low 16 bits of the second word. All timing comes from a parameterised divider in the system clock domain. One parameter sets the half bit period. A longer guard interval surrounds every select edge.

Top module: `spi24_regmaster`

## Requirements
- R1: Every frame is exactly 24 bits and is shifted out most significant bit first.
- R2: After reset and whenever the select is high, the serial clock is high. Each data bit is placed on the output while the clock is low, and it is held across the following rising edge.
- R3: The select word is 0x70 in bits 23:16, zero in bits 15:8 and the register number in bits 7:0. The store word is 0x72 in bits 23:16 with the 16-bit value below it. The fetch word is 0x73 in bits 23:16 with zero below it.
- R4: A write produces exactly the select word followed by the store word. A read produces exactly the select word followed by the fetch word.
- R5: On completion, done is high for exactly one cycle. On a read, rdata then holds bits 15:0 of the 24 bits captured during the fetch word; the upper 8 captured bits are discarded. On a write, rdata is zero.
- R6: The select stays low for 2*GUARD_CYC + 48*HALF_DIV system cycles per frame. The first GUARD_CYC cycles come before the first clock fall and the last GUARD_CYC cycles come after the last rise. Each clock half lasts HALF_DIV cycles.
- R7: Between the two frames of one access, the select is high for GUARD_CYC + 2 cycles.
- R8: Reset leaves select high, busy low and done low. A request is accepted at a clock edge where it is present and busy is low. From that edge busy is high, and the select falls one cycle later. The done pulse begins GUARD_CYC + 1 cycles after the second select rise, and busy falls at that same time.
- R9: Requests presented while busy is high are ignored: they add no frame, and their register number and value are never used.
- R10: With HAS_SDI set to 0, a read returns zero on rdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when busy is low |
| req_write | input | 1 | 1 for a register write, 0 for a read |
| req_addr | input | 8 | Register number |
| req_wdata | input | 16 | Value to write |
| busy | output | 1 | Access in progress; requests ignored |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid with done |
| spi_cs_n | output | 1 | Active-low frame select |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The bench drives each request just after a falling system-clock edge and samples every falling edge after that. It timestamps each select transition and the done pulse by sample number. The expected schedule follows from the requirements. The first select fall is seen on the second sample. Each low stretch lasts 2*GUARD_CYC + 48*HALF_DIV samples and the high gap between frames lasts GUARD_CYC + 2. The done pulse appears GUARD_CYC + 1 samples after the last select rise, and it is gone on the next sample. A behavioural device model decodes the frames on the rising serial clock and answers reads from its own register array. The bench checks the captured words and rdata against a separate expected register image that it updates from its own requests.

// File: rtl/spi24_pkg.sv
package spi24_pkg;

  localparam int FRAME_W = 24;
  localparam int OP_W    = 8;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 8;

  localparam logic [OP_W-1:0] OP_SELECT = 8'h70;
  localparam logic [OP_W-1:0] OP_STORE  = 8'h72;
  localparam logic [OP_W-1:0] OP_FETCH  = 8'h73;

  typedef logic [FRAME_W-1:0] frame_t;

  // Word that names the target register.
  function automatic frame_t mk_select(input logic [ADDR_W-1:0] regno);
    return {OP_SELECT, {(FRAME_W-OP_W-ADDR_W){1'b0}}, regno};
  endfunction

  // Word that carries a value to be stored.
  function automatic frame_t mk_store(input logic [DATA_W-1:0] value);
    return {OP_STORE, value};
  endfunction

  // Word that fetches the selected register.
  function automatic frame_t mk_fetch();
    return {OP_FETCH, {DATA_W{1'b0}}};
  endfunction

  // Result handed back to the requester.
  function automatic logic [DATA_W-1:0] result_of(input bit has_sdi,
                                                  input bit is_write,
                                                  input frame_t captured);
    if (has_sdi && !is_write) return captured[DATA_W-1:0];
    return '0;
  endfunction

  // Cycles the select spends low for one frame.
  function automatic int unsigned select_low_cycles(input int unsigned half,
                                                    input int unsigned guard);
    return 2 * guard + 2 * FRAME_W * half;
  endfunction

endpackage

// File: rtl/spi24_divider.sv
module spi24_divider #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  output logic             expired
);

  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= len - LEN_W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - LEN_W'(1);
    end
  end

  assign expired = (cnt == '0);

  // R6: a phase of zero length would break the timing schedule.
  a_r6_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (len != '0));

endmodule

// File: rtl/spi24_shifter.sv
module spi24_shifter
  import spi24_pkg::*;
#(
  parameter int HALF_DIV  = 4,
  parameter int GUARD_CYC = 10,
  parameter bit HAS_SDI   = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  frame_t frame_in,
  input  logic   sdi,
  output logic   cs_n,
  output logic   sck,
  output logic   sdo,
  output frame_t cap_word,
  output logic   fdone
);

  localparam int LEN_MAX = (HALF_DIV > GUARD_CYC) ? HALF_DIV : GUARD_CYC;
  localparam int LEN_W   = $clog2(LEN_MAX + 1);
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam logic [LEN_W-1:0] HALF_LEN  = LEN_W'(HALF_DIV);
  localparam logic [LEN_W-1:0] GUARD_LEN = LEN_W'(GUARD_CYC);
  localparam logic [BIT_W-1:0] TOP_BIT   = BIT_W'(FRAME_W - 1);

  typedef enum logic [2:0] {
    SH_IDLE,
    SH_LEAD,
    SH_LOW,
    SH_HIGH,
    SH_TRAIL,
    SH_GAP
  } sh_state_e;

  sh_state_e        st;
  logic [BIT_W-1:0] bitcnt;
  frame_t           shreg;
  logic             tload;
  logic [LEN_W-1:0] tlen;
  logic             expired;

  // Named internal events.
  logic take, lead_end, rise_now, fall_now, last_bit_end, trail_end, gap_end;

  assign take         = (st == SH_IDLE) && start;
  assign lead_end     = (st == SH_LEAD) && expired;
  assign rise_now     = (st == SH_LOW) && expired;
  assign fall_now     = (st == SH_HIGH) && expired && (bitcnt != '0);
  assign last_bit_end = (st == SH_HIGH) && expired && (bitcnt == '0);
  assign trail_end    = (st == SH_TRAIL) && expired;
  assign gap_end      = (st == SH_GAP) && expired;

  always_comb begin
    tload = take | lead_end | rise_now | fall_now | last_bit_end | trail_end;
    tlen  = (lead_end | rise_now | fall_now) ? HALF_LEN : GUARD_LEN;
  end

  spi24_divider #(.LEN_W(LEN_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tload),
    .len    (tlen),
    .expired(expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SH_IDLE;
      cs_n   <= 1'b1;
      sck    <= 1'b1;
      sdo    <= 1'b1;
      bitcnt <= '0;
      shreg  <= '0;
      fdone  <= 1'b0;
    end else begin
      fdone <= 1'b0;
      if (take) begin
        st     <= SH_LEAD;
        cs_n   <= 1'b0;
        shreg  <= frame_in;
        bitcnt <= TOP_BIT;
      end
      if (lead_end) begin
        st  <= SH_LOW;
        sck <= 1'b0;
        sdo <= shreg[FRAME_W-1];
      end
      if (rise_now) begin
        st  <= SH_HIGH;
        sck <= 1'b1;
      end
      if (fall_now) begin
        st     <= SH_LOW;
        sck    <= 1'b0;
        bitcnt <= bitcnt - BIT_W'(1);
        shreg  <= shreg << 1;
        sdo    <= shreg[FRAME_W-2];
      end
      if (last_bit_end) begin
        st <= SH_TRAIL;
      end
      if (trail_end) begin
        st   <= SH_GAP;
        cs_n <= 1'b1;
        sdo  <= 1'b1;
      end
      if (gap_end) begin
        st    <= SH_IDLE;
        fdone <= 1'b1;
      end
    end
  end

  generate
    if (HAS_SDI) begin : g_capture
      frame_t capreg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          capreg <= '0;
        end else if (take) begin
          capreg <= '0;
        end else if (rise_now) begin
          capreg <= {capreg[FRAME_W-2:0], sdi};
        end
      end
      assign cap_word = capreg;
    end else begin : g_no_capture
      assign cap_word = '0;
    end
  endgenerate

  // R2: the clock rests high whenever no frame is selected.
  a_r2_sck_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sck);

  // R2: the data line does not move at a rising clock edge.
  a_r2_sdo_hold_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(sdo));

  // R6: the select remains low throughout the bit phases.
  a_r6_cs_low_in_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == SH_LOW) || (st == SH_HIGH)) |-> !cs_n);

  // R1: shifting always begins from the most significant bit.
  a_r1_start_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SH_LEAD) |-> (bitcnt == TOP_BIT));

endmodule

// File: rtl/spi24_seq.sv
module spi24_seq
  import spi24_pkg::*;
#(
  parameter bit HAS_SDI = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              fdone,
  input  frame_t            cap_word,
  output logic              fstart,
  output frame_t            frame_out,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  typedef enum logic [1:0] {
    Q_IDLE,
    Q_SEL,
    Q_DATA
  } q_state_e;

  q_state_e          st;
  logic              lat_write;
  logic [DATA_W-1:0] lat_wdata;

  logic accept, sel_end, data_end;
  assign accept   = req_valid && (st == Q_IDLE);
  assign sel_end  = fdone && (st == Q_SEL);
  assign data_end = fdone && (st == Q_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= Q_IDLE;
      fstart    <= 1'b0;
      frame_out <= '0;
      done      <= 1'b0;
      rdata     <= '0;
      lat_write <= 1'b0;
      lat_wdata <= '0;
    end else begin
      fstart <= 1'b0;
      done   <= 1'b0;
      if (accept) begin
        st        <= Q_SEL;
        fstart    <= 1'b1;
        frame_out <= mk_select(req_addr);
        lat_write <= req_write;
        lat_wdata <= req_wdata;
      end
      if (sel_end) begin
        st        <= Q_DATA;
        fstart    <= 1'b1;
        frame_out <= lat_write ? mk_store(lat_wdata) : mk_fetch();
      end
      if (data_end) begin
        st    <= Q_IDLE;
        done  <= 1'b1;
        rdata <= result_of(HAS_SDI, lat_write, cap_word);
      end
    end
  end

  assign busy = (st != Q_IDLE);

  // R5: completion is a single-cycle pulse.
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: frame completions arrive only inside an access.
  a_r4_fdone_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    fdone |-> busy);

  // R4: the first frame's end launches the second frame.
  a_r4_second_launch: assert property (@(posedge clk) disable iff (!rst_n)
    sel_end |=> (fstart && busy));

  // R8: an accepted request raises busy from the next cycle.
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  generate
    if (!HAS_SDI) begin : g_no_sdi_chk
      // R10: without a return line, results are zero.
      a_r10_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rdata == '0));
    end
  endgenerate

endmodule

// File: rtl/spi24_regmaster.sv
module spi24_regmaster
  import spi24_pkg::*;
#(
  parameter int HALF_DIV  = 4,
  parameter int GUARD_CYC = 10,
  parameter bit HAS_SDI   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);

  logic   fstart;
  logic   fdone;
  frame_t frame_w;
  frame_t cap_w;

  spi24_seq #(.HAS_SDI(HAS_SDI)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .fdone    (fdone),
    .cap_word (cap_w),
    .fstart   (fstart),
    .frame_out(frame_w),
    .busy     (busy),
    .done     (done),
    .rdata    (rdata)
  );

  spi24_shifter #(
    .HALF_DIV (HALF_DIV),
    .GUARD_CYC(GUARD_CYC),
    .HAS_SDI  (HAS_SDI)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (fstart),
    .frame_in(frame_w),
    .sdi     (spi_miso),
    .cs_n    (spi_cs_n),
    .sck     (spi_sck),
    .sdo     (spi_mosi),
    .cap_word(cap_w),
    .fdone   (fdone)
  );

  // R8: the select never falls while the block reports idle.
  a_r8_select_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> busy);

endmodule

// File: tb/test_spi24_regmaster.sv
module test_spi24_regmaster;

  localparam int H = 3;
  localparam int G = 8;
  localparam int LOW_LEN = 2 * G + 48 * H;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        req_valid, req_write;
  logic [7:0]  req_addr;
  logic [15:0] req_wdata;
  logic        busy, done;
  logic [15:0] rdata;
  logic        cs_n, sck, mosi;
  logic        miso = 1'b1;

  spi24_regmaster #(.HALF_DIV(H), .GUARD_CYC(G), .HAS_SDI(1'b1)) i_spi24_regmaster (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso)
  );

  // Variant without a return line.
  logic        n_valid, n_busy, n_done, n_cs, n_sck, n_mosi;
  logic [15:0] n_rdata;
  spi24_regmaster #(.HALF_DIV(H), .GUARD_CYC(G), .HAS_SDI(1'b0)) i_spi24_regmaster_nosdi (
    .clk(clk), .rst_n(rst_n), .req_valid(n_valid), .req_write(1'b0),
    .req_addr(8'h03), .req_wdata(16'h0000), .busy(n_busy), .done(n_done),
    .rdata(n_rdata), .spi_cs_n(n_cs), .spi_sck(n_sck), .spi_mosi(n_mosi),
    .spi_miso(1'b1)
  );

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural device model.
  logic [15:0] dev_mem [256];
  logic [7:0]  dev_sel = 8'h00;
  logic [23:0] rx;
  int          rxn = 0;
  logic [23:0] resp;
  int          bpos = 23;
  logic [23:0] frames [$];
  int          bad_len = 0;

  always @(negedge cs_n) begin
    rxn  = 0;
    rx   = '0;
    resp = {8'hA5, dev_mem[dev_sel]};
    bpos = 23;
  end

  always @(posedge sck) if (!cs_n) begin
    rx  = {rx[22:0], mosi};
    rxn = rxn + 1;
  end

  always @(negedge sck) if (!cs_n) begin
    miso <= resp[bpos];
    if (bpos > 0) bpos = bpos - 1;
  end

  always @(posedge cs_n) begin
    if (rxn == 24) begin
      frames.push_back(rx);
      if (rx[23:16] == 8'h70) dev_sel = rx[7:0];
      if (rx[23:16] == 8'h72) dev_mem[dev_sel] = rx[15:0];
    end else if (rxn != 0) begin
      bad_len++;
    end
    rxn = 0;
  end

  logic [15:0] exp_mem [256];

  function automatic logic [15:0] seed_val(input int i);
    return 16'(i * 16'h0101) ^ 16'h3C5A;
  endfunction

  task automatic access(input bit wr, input logic [7:0] a, input logic [15:0] d,
                        input bit junk);
    int fall1 = -1, rise1 = -1, fall2 = -1, rise2 = -1, done_k = -1;
    int nf = 0, nr = 0, sck_bad = 0;
    bit prev = 1'b1;
    bit busy_k1 = 1'b0;
    logic [23:0] e0, e1;
    @(negedge clk);
    frames.delete();
    bad_len   = 0;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    for (int k = 1; k < 3000; k++) begin
      @(negedge clk);
      if (k == 1) begin
        busy_k1 = busy;
        if (junk) begin
          req_write = 1'b1;
          req_addr  = ~a;
          req_wdata = ~d;
        end else begin
          req_valid = 1'b0;
        end
      end
      if (k == 60) req_valid = 1'b0;
      if (cs_n && !sck) sck_bad++;
      if (prev && !cs_n) begin nf++; if (nf == 1) fall1 = k; else fall2 = k; end
      if (!prev && cs_n) begin nr++; if (nr == 1) rise1 = k; else rise2 = k; end
      prev = cs_n;
      if (done) begin done_k = k; break; end
    end
    chk(done_k > 0, "R8", "done seen", done_k, 1);
    chk(busy_k1, "R8", "busy after accept", busy_k1, 1);
    chk(!busy, "R8", "busy low with done", busy, 0);
    chk(sck_bad == 0, "R2", "sck high while cs high", sck_bad, 0);
    chk(fall1 == 2, "R8", "cs fall delay", fall1, 2);
    chk(rise1 - fall1 == LOW_LEN, "R6", "first frame low", rise1 - fall1, LOW_LEN);
    chk(fall2 - rise1 == G + 2, "R7", "inter-frame gap", fall2 - rise1, G + 2);
    chk(rise2 - fall2 == LOW_LEN, "R6", "second frame low", rise2 - fall2, LOW_LEN);
    chk(done_k - rise2 == G + 1, "R8", "done after last rise", done_k - rise2, G + 1);
    chk(bad_len == 0, "R1", "frame bit count", bad_len, 0);
    chk(frames.size() == 2, junk ? "R9" : "R4", "frame count", frames.size(), 2);
    e0 = {8'h70, 8'h00, a};
    e1 = wr ? {8'h72, d} : 24'h730000;
    if (frames.size() == 2) begin
      chk(frames[0] == e0, "R3", "select word", frames[0], e0);
      chk(frames[1] == e1, "R3", "data word", frames[1], e1);
    end
    if (wr) begin
      chk(rdata == 16'h0000, "R5", "write result", rdata, 0);
      exp_mem[a] = d;
    end else begin
      chk(rdata == exp_mem[a], "R5", "read result", rdata, exp_mem[a]);
    end
    @(negedge clk);
    chk(!done, "R5", "done one cycle", done, 0);
  endtask

  initial begin
    logic [7:0] recent [4];
    void'($urandom(32'd20417));
    for (int i = 0; i < 256; i++) begin
      dev_mem[i] = seed_val(i);
      exp_mem[i] = seed_val(i);
    end
    recent[0] = 8'h00; recent[1] = 8'hFF; recent[2] = 8'hB0; recent[3] = 8'h5A;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; n_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1, "R8", "reset cs", cs_n, 1);
    chk(sck == 1'b1, "R2", "reset sck", sck, 1);
    chk(busy == 1'b0, "R8", "reset busy", busy, 0);
    chk(done == 1'b0, "R8", "reset done", done, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Directed corner cases.
    access(1'b0, 8'hB0, 16'h0000, 1'b0);
    access(1'b1, 8'h00, 16'h0000, 1'b0);
    access(1'b1, 8'hFF, 16'hFFFF, 1'b0);
    access(1'b0, 8'h00, 16'h0000, 1'b0);
    access(1'b0, 8'hFF, 16'h0000, 1'b0);
    access(1'b1, 8'h5A, 16'h8001, 1'b1);   // R9: junk held during busy
    access(1'b0, 8'hA5, 16'h0000, 1'b0);   // inverted address must be untouched
    access(1'b0, 8'h5A, 16'h0000, 1'b0);

    // Constrained random mix.
    for (int n = 0; n < 24; n++) begin
      bit          wr = 1'($urandom_range(0, 1));
      logic [7:0]  a  = ($urandom_range(0, 2) == 0) ? recent[$urandom_range(0, 3)]
                                                  : 8'($urandom_range(0, 255));
      logic [15:0] d  = 16'($urandom_range(0, 65535));
      if (wr) recent[n % 4] = a;
      access(wr, a, d, ($urandom_range(0, 5) == 0));
    end

    // R10: no return line fitted.
    begin
      int nk = -1;
      @(negedge clk);
      n_valid = 1'b1;
      for (int k = 1; k < 3000; k++) begin
        @(negedge clk);
        n_valid = 1'b0;
        if (n_done) begin nk = k; break; end
      end
      chk(nk > 0, "R10", "nosdi done seen", nk, 1);
      chk(n_rdata == 16'h0000, "R10", "nosdi read result", n_rdata, 0);
    end

    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule